// File: doc/BRIEF.md
# Extended opcode prefix classifier

This block sits at an instruction boundary of a byte-stream decoder. It takes a window of instruction bytes, starting at the boundary, and decides whether the leading byte opens an extended vector prefix or is an ordinary legacy instruction byte. Several lead byte values are overloaded: C4, C5, 62, D4 and D5 are legacy instructions in 32-bit mode and prefixes otherwise. The block settles each case from the processor mode, a control enable, and the two top bits of the byte that follows.

For a prefix, the block reports a kind code and a length in bytes. It also passes on the payload bytes that follow the lead byte. For the four-byte 62 form it reports a vendor-territory bit and flags a nonzero reserved field. For a legacy byte it reports which overloaded instruction was seen. When the window holds too few valid bytes to settle the question, the block returns a need-more-bytes result and no decision.

Windows arrive on a valid/ready input, and results leave on a valid/ready output through one register stage. A window is accepted on a cycle where `in_valid` and `in_ready` are both high. Its result shows on `out_valid` in the next cycle. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new window is taken.

Top module: `pfx_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A window accepted while `in_valid` and `in_ready` are both high produces `out_valid` = 1 in the next cycle. While `out_valid` = 1 and `out_ready` = 0, the outputs hold and `in_ready` is 0.
- R3: In 32-bit mode (`long_mode` = 0), lead byte C4, C5 or 62 is a prefix only when bits 7:6 of byte 1 are 11. Otherwise the result is legacy with `out_legacy` = 2 for C4, 3 for C5 and 4 for 62, and with `out_detected` = 0 and `out_len` = 0.
- R4: In 64-bit mode (`long_mode` = 1), C4, C5 and 62 are always prefixes, whatever byte 1 holds.
- R5: A detected prefix reports a kind and a length. C4 gives kind 1 and length 3. C5 gives kind 2 and length 2. 62 gives kind 3 and length 4. D4 gives kind 4 and length 3. D5 gives kind 5 and length 2.
- R6: For a 62 prefix, payload slots 0..2 carry bytes 1..3. `out_vendor` equals bit 7 of byte 3.
- R7: For a 62 prefix, `out_invalid` is 1 exactly when bits 6:0 of byte 3 are nonzero. It is 0 for every other result.
- R8: In 32-bit mode with `alt_en` = 1, D4 and D5 are prefixes only when bits 7:6 of byte 1 are 11, and otherwise legacy with code 5 for D4 and 6 for D5. With `alt_en` = 0, they are always legacy, whatever byte 1 holds.
- R9: With parameter `ALT_LONG_ONLY` = 1, D4 and D5 are always legacy in 32-bit mode, even with `alt_en` = 1. They stay prefixes in 64-bit mode.
- R10: In 64-bit mode, D4 and D5 are always prefixes.
- R11: The result is need-more-bytes (`out_need_more` = 1, with detected, kind, len, legacy and invalid all 0) in three cases: byte 0 is invalid; the byte-1 test is needed and byte 1 is invalid; or a prefix is chosen and one of its bytes is invalid.
- R12: Any lead byte other than C4, C5, 62, D4 or D5 gives a legacy result with `out_legacy` = 1, `out_len` = 0 and `out_detected` = 0.
- R13: Payload slot k (bits 8k+7:8k) holds byte k+1 when k+1 is less than the prefix length. Otherwise it holds 0. The whole payload is 0 for non-prefix results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Window accepted this cycle when high with in_valid |
| in_bytes | input | WIN*8 | Byte k at bits 8k+7:8k, byte 0 at the boundary |
| in_byte_vld | input | WIN | Valid flag per byte |
| long_mode | input | 1 | 1 = 64-bit mode |
| alt_en | input | 1 | Enables D4/D5 prefixes in 32-bit mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_need_more | output | 1 | Too few valid bytes, no decision |
| out_detected | output | 1 | Prefix found |
| out_kind | output | 3 | Prefix kind code (0 = none) |
| out_len | output | 3 | Prefix length in bytes (0 = none) |
| out_payload | output | (WIN-1)*8 | Payload bytes after the lead byte |
| out_vendor | output | 1 | Vendor-territory bit of a 62 prefix |
| out_invalid | output | 1 | Reserved bits of a 62 prefix nonzero |
| out_legacy | output | 3 | Legacy identification (0 none, 1 other, 2..6 overloaded bytes) |

## Verification
The hardest situation to reach is the boundary between need-more-bytes and a final decision. The same lead byte can be settled, or left waiting for more bytes, depending on the mode, the enable and the validity of later bytes. The bench reaches it with partially valid windows. One gives a 62 lead in 64-bit mode with its last byte invalid. Another gives D5 in 32-bit mode with the enable off and only byte 0 valid, which must still settle as legacy. A second instance built with the 64-bit-only option covers the parameter variant, and a held result under back-pressure shows that a waiting window is not taken.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_L3   = 3'd1,
    KIND_L2   = 3'd2,
    KIND_W4   = 3'd3,
    KIND_A3   = 3'd4,
    KIND_A2   = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    LEG_NONE  = 3'd0,
    LEG_OTHER = 3'd1,
    LEG_C4    = 3'd2,
    LEG_C5    = 3'd3,
    LEG_62    = 3'd4,
    LEG_D4    = 3'd5,
    LEG_D5    = 3'd6
  } leg_e;

  typedef enum logic [2:0] {
    LD_NONE = 3'd0,
    LD_C4   = 3'd1,
    LD_C5   = 3'd2,
    LD_62   = 3'd3,
    LD_D4   = 3'd4,
    LD_D5   = 3'd5
  } lead_e;

  typedef struct packed {
    logic       need_more;
    logic       detected;
    kind_e      kind;
    logic [2:0] len;
    leg_e       legacy;
    logic       vendor;
    logic       invalid;
  } cls_t;

  localparam int CLS_W = $bits(cls_t);

  function automatic logic [2:0] kind_len(kind_e k);
    case (k)
      KIND_L3, KIND_A3: kind_len = 3'd3;
      KIND_L2, KIND_A2: kind_len = 3'd2;
      KIND_W4:          kind_len = 3'd4;
      default:          kind_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pfx_lead_decode.sv
module pfx_lead_decode
  import pfx_pkg::*;
(
  input  logic [7:0] lead,
  output lead_e      lead_cls,
  output leg_e       lead_leg,
  output kind_e      lead_kind
);

  always_comb begin
    lead_cls  = LD_NONE;
    lead_leg  = LEG_OTHER;
    lead_kind = KIND_NONE;
    case (lead)
      8'hC4: begin lead_cls = LD_C4; lead_leg = LEG_C4; lead_kind = KIND_L3; end
      8'hC5: begin lead_cls = LD_C5; lead_leg = LEG_C5; lead_kind = KIND_L2; end
      8'h62: begin lead_cls = LD_62; lead_leg = LEG_62; lead_kind = KIND_W4; end
      8'hD4: begin lead_cls = LD_D4; lead_leg = LEG_D4; lead_kind = KIND_A3; end
      8'hD5: begin lead_cls = LD_D5; lead_leg = LEG_D5; lead_kind = KIND_A2; end
      default: ;
    endcase
  end

endmodule

// File: rtl/pfx_class.sv
module pfx_class
  import pfx_pkg::*;
#(
  parameter int WIN           = 4,
  parameter bit ALT_LONG_ONLY = 1'b0,
  parameter int VENDOR_BIT    = 7,
  localparam int PAY_W        = (WIN - 1) * 8
) (
  input  logic [WIN*8-1:0] bytes_i,
  input  logic [WIN-1:0]   vld_i,
  input  logic             long_mode,
  input  logic             alt_en,
  output cls_t             res,
  output logic [PAY_W-1:0] payload
);

  localparam logic [7:0] VMASK = 8'(1 << VENDOR_BIT);

  logic [7:0] b1, b3;
  lead_e      lcls;
  leg_e       lleg;
  kind_e      lkind;
  logic       top_set, alt_ok32;
  logic       want_pfx, need, missing;
  leg_e       leg;
  logic [2:0] plen;

  assign b1 = bytes_i[15:8];
  assign b3 = bytes_i[31:24];
  assign top_set  = (b1[7:6] == 2'b11);
  assign alt_ok32 = alt_en && !ALT_LONG_ONLY;

  pfx_lead_decode u_lead (
    .lead      (bytes_i[7:0]),
    .lead_cls  (lcls),
    .lead_leg  (lleg),
    .lead_kind (lkind)
  );

  always_comb begin
    want_pfx = 1'b0;
    need     = 1'b0;
    leg      = LEG_NONE;
    case (lcls)
      LD_C4, LD_C5, LD_62: begin
        if (long_mode)       want_pfx = 1'b1;
        else if (!vld_i[1])  need     = 1'b1;
        else if (top_set)    want_pfx = 1'b1;
        else                 leg      = lleg;
      end
      LD_D4, LD_D5: begin
        if (long_mode)       want_pfx = 1'b1;
        else if (!alt_ok32)  leg      = lleg;
        else if (!vld_i[1])  need     = 1'b1;
        else if (top_set)    want_pfx = 1'b1;
        else                 leg      = lleg;
      end
      default: leg = LEG_OTHER;
    endcase
    if (!vld_i[0]) begin
      want_pfx = 1'b0;
      need     = 1'b1;
      leg      = LEG_NONE;
    end
  end

  always_comb begin
    missing = 1'b0;
    for (int i = 1; i < WIN; i++) begin
      if (want_pfx && (i < int'(kind_len(lkind))) && !vld_i[i]) missing = 1'b1;
    end
  end

  always_comb begin
    res = '0;
    res.need_more = need || missing;
    res.legacy    = leg;
    if (want_pfx && !missing) begin
      res.detected = 1'b1;
      res.kind     = lkind;
      res.len      = kind_len(lkind);
      if (lcls == LD_62) begin
        res.vendor  = |(b3 & VMASK);
        res.invalid = |(b3 & ~VMASK);
      end
    end
  end

  assign plen = res.len;

  for (genvar k = 0; k < WIN - 1; k++) begin : g_pay
    assign payload[8*k +: 8] = ((k + 1) < int'(plen)) ? bytes_i[8*(k+1) +: 8] : 8'h00;
  end

endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

endmodule

// File: rtl/pfx_classifier.sv
module pfx_classifier
  import pfx_pkg::*;
#(
  parameter int WIN           = 4,
  parameter bit ALT_LONG_ONLY = 1'b0,
  parameter int VENDOR_BIT    = 7,
  localparam int PAY_W        = (WIN - 1) * 8,
  localparam int ST_W         = CLS_W + PAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIN*8-1:0] in_bytes,
  input  logic [WIN-1:0]   in_byte_vld,
  input  logic             long_mode,
  input  logic             alt_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_need_more,
  output logic             out_detected,
  output logic [2:0]       out_kind,
  output logic [2:0]       out_len,
  output logic [PAY_W-1:0] out_payload,
  output logic             out_vendor,
  output logic             out_invalid,
  output logic [2:0]       out_legacy
);

  cls_t             c_res, q_res;
  logic [PAY_W-1:0] c_pay, q_pay;
  logic [ST_W-1:0]  q_bus;

  pfx_class #(
    .WIN           (WIN),
    .ALT_LONG_ONLY (ALT_LONG_ONLY),
    .VENDOR_BIT    (VENDOR_BIT)
  ) u_class (
    .bytes_i   (in_bytes),
    .vld_i     (in_byte_vld),
    .long_mode (long_mode),
    .alt_en    (alt_en),
    .res       (c_res),
    .payload   (c_pay)
  );

  pfx_out_stage #(.W(ST_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  ({c_res, c_pay}),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (q_bus)
  );

  assign {q_res, q_pay} = q_bus;

  assign out_need_more = q_res.need_more;
  assign out_detected  = q_res.detected;
  assign out_kind      = q_res.kind;
  assign out_len       = q_res.len;
  assign out_legacy    = q_res.legacy;
  assign out_vendor    = q_res.vendor;
  assign out_invalid   = q_res.invalid;
  assign out_payload   = q_pay;

endmodule

// File: rtl/pfx_classifier_chk.sv
module pfx_classifier_chk #(
  parameter int PAY_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_need_more,
  input logic             out_detected,
  input logic [2:0]       out_kind,
  input logic [2:0]       out_len,
  input logic [PAY_W-1:0] out_payload,
  input logic             out_vendor,
  input logic             out_invalid,
  input logic [2:0]       out_legacy
);

  // R2: an accepted window yields a result one cycle later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2: a stalled result stays frozen
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload) && $stable(out_kind)
                                   && $stable(out_len) && $stable(out_legacy)
                                   && $stable(out_need_more) && $stable(out_vendor)));

  // R2: no window is taken while a result is stalled
  a_r2_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11: need-more carries no decision
  a_r11_no_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_need_more) |-> (!out_detected && out_len == 3'd0 && out_legacy == 3'd0
                                      && !out_invalid));

  // R5: length agrees with kind
  a_r5_len_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_detected) |-> ((out_kind == 3'd3) == (out_len == 3'd4))
                                     && (out_len != 3'd0) && (out_legacy == 3'd0));

  // R7: invalid and vendor flags only on the four-byte form
  a_r7_flags_w4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_invalid || out_vendor)) |-> (out_detected && out_kind == 3'd3));

  // R13: non-prefix results carry a zero payload
  a_r13_zero_pay: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_detected) |-> (out_payload == '0));

endmodule

bind pfx_classifier pfx_classifier_chk #(.PAY_W(PAY_W)) u_chk (.*);

// File: tb/pfx_classifier_tb.sv
module pfx_classifier_tb;

  localparam int WIN = 4;
  localparam int PW  = (WIN - 1) * 8;
  localparam int EW  = 1 + 1 + 3 + 3 + 3 + 1 + 1 + PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             in_valid = 1'b0, out_ready = 1'b1;
  logic [WIN*8-1:0] in_bytes = '0;
  logic [WIN-1:0]   in_byte_vld = '0;
  logic             long_mode = 1'b0, alt_en = 1'b1;

  logic in_ready, out_valid, o_need, o_det, o_ven, o_inv;
  logic [2:0] o_kind, o_len, o_leg;
  logic [PW-1:0] o_pay;
  logic l_in_ready, l_out_valid, l_need, l_det, l_ven, l_inv;
  logic [2:0] l_kind, l_len, l_leg;
  logic [PW-1:0] l_pay;

  pfx_classifier #(.WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_byte_vld(in_byte_vld), .long_mode(long_mode), .alt_en(alt_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_need_more(o_need),
    .out_detected(o_det), .out_kind(o_kind), .out_len(o_len), .out_payload(o_pay),
    .out_vendor(o_ven), .out_invalid(o_inv), .out_legacy(o_leg)
  );

  pfx_classifier #(.WIN(WIN), .ALT_LONG_ONLY(1'b1)) u_lo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(l_in_ready),
    .in_bytes(in_bytes), .in_byte_vld(in_byte_vld), .long_mode(long_mode), .alt_en(alt_en),
    .out_valid(l_out_valid), .out_ready(out_ready), .out_need_more(l_need),
    .out_detected(l_det), .out_kind(l_kind), .out_len(l_len), .out_payload(l_pay),
    .out_vendor(l_ven), .out_invalid(l_inv), .out_legacy(l_leg)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [EW-1:0] pk(logic nd, logic dt, logic [2:0] kd, logic [2:0] ln,
                                       logic [2:0] lg, logic vn, logic iv, logic [PW-1:0] py);
    return {nd, dt, kd, ln, lg, vn, iv, py};
  endfunction

  task automatic check(string req, logic [EW-1:0] act, logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one window, sample the registered result one cycle later.
  task automatic apply(string req, bit lo, logic lm, logic ae, logic [31:0] b, logic [3:0] v,
                       logic [EW-1:0] exp);
    @(negedge clk);
    in_bytes = b; in_byte_vld = v; long_mode = lm; alt_en = ae; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (lo) check(req, {l_out_valid, pk(l_need, l_det, l_kind, l_len, l_leg, l_ven, l_inv, l_pay)},
                  {1'b1, exp});
    else    check(req, {out_valid, pk(o_need, o_det, o_kind, o_len, o_leg, o_ven, o_inv, o_pay)},
                  {1'b1, exp});
  endtask

  task automatic t_reset();
    check("R1", {EW'(0), out_valid, in_ready}, {EW'(0), 1'b0, 1'b1});
  endtask

  task automatic t_mode32();
    apply("R3", 0, 0, 1, 32'h00_7D_E2_C4, 4'hF, pk(0, 1, 1, 3, 0, 0, 0, 24'h007DE2));
    apply("R3", 0, 0, 1, 32'h00_00_3F_C4, 4'hF, pk(0, 0, 0, 0, 2, 0, 0, 24'h0));
    apply("R3", 0, 0, 1, 32'h00_00_80_C5, 4'hF, pk(0, 0, 0, 0, 3, 0, 0, 24'h0));
    apply("R3", 0, 0, 1, 32'h00_00_40_62, 4'hF, pk(0, 0, 0, 0, 4, 0, 0, 24'h0));
    // R13: bytes after a two-byte prefix are not passed on
    apply("R13", 0, 0, 1, 32'hBB_AA_F8_C5, 4'hF, pk(0, 1, 2, 2, 0, 0, 0, 24'h0000F8));
  endtask

  task automatic t_mode64();
    apply("R4", 0, 1, 1, 32'h00_11_05_C4, 4'hF, pk(0, 1, 1, 3, 0, 0, 0, 24'h001105));
    apply("R4", 0, 1, 0, 32'h00_00_12_C5, 4'h3, pk(0, 1, 2, 2, 0, 0, 0, 24'h000012));
    apply("R5", 0, 1, 1, 32'h00_34_12_62, 4'hF, pk(0, 1, 3, 4, 0, 0, 0, 24'h003412));
  endtask

  task automatic t_wide();
    apply("R6", 0, 0, 1, 32'h80_22_D1_62, 4'hF, pk(0, 1, 3, 4, 0, 1, 0, 24'h8022D1));
    apply("R7", 0, 0, 1, 32'h81_01_F0_62, 4'hF, pk(0, 1, 3, 4, 0, 1, 1, 24'h8101F0));
    apply("R7", 0, 1, 1, 32'h04_01_F0_62, 4'hF, pk(0, 1, 3, 4, 0, 0, 1, 24'h0401F0));
  endtask

  task automatic t_alt();
    apply("R8", 0, 0, 1, 32'h00_55_C7_D4, 4'hF, pk(0, 1, 4, 3, 0, 0, 0, 24'h0055C7));
    apply("R8", 0, 0, 0, 32'h00_00_C0_D5, 4'hF, pk(0, 0, 0, 0, 6, 0, 0, 24'h0));
    apply("R8", 0, 0, 1, 32'h00_00_0A_D4, 4'hF, pk(0, 0, 0, 0, 5, 0, 0, 24'h0));
    apply("R10", 0, 1, 0, 32'h00_00_0A_D5, 4'hF, pk(0, 1, 5, 2, 0, 0, 0, 24'h00000A));
    apply("R9", 1, 0, 1, 32'h00_00_C0_D4, 4'hF, pk(0, 0, 0, 0, 5, 0, 0, 24'h0));
    apply("R9", 1, 1, 1, 32'h00_33_0A_D4, 4'hF, pk(0, 1, 4, 3, 0, 0, 0, 24'h00330A));
  endtask

  task automatic t_short();
    apply("R11", 0, 0, 1, 32'h00_00_00_C4, 4'h0, pk(1, 0, 0, 0, 0, 0, 0, 24'h0));
    apply("R11", 0, 0, 1, 32'h00_00_C0_C4, 4'h1, pk(1, 0, 0, 0, 0, 0, 0, 24'h0));
    apply("R11", 0, 1, 1, 32'h81_34_12_62, 4'h7, pk(1, 0, 0, 0, 0, 0, 0, 24'h0));
    apply("R11", 0, 0, 0, 32'h00_00_00_D5, 4'h1, pk(0, 0, 0, 0, 6, 0, 0, 24'h0));
    apply("R12", 0, 1, 1, 32'h00_00_C0_90, 4'h1, pk(0, 0, 0, 0, 1, 0, 0, 24'h0));
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_bytes = 32'h00_00_F8_C5; in_byte_vld = 4'hF; long_mode = 0; alt_en = 1; in_valid = 1'b1;
    @(negedge clk);
    in_bytes = 32'h00_00_00_90;
    check("R2", {EW'(0), out_valid, in_ready}, {EW'(0), 1'b1, 1'b0});
    @(negedge clk);
    check("R2", {out_valid, pk(o_need, o_det, o_kind, o_len, o_leg, o_ven, o_inv, o_pay)},
          {1'b1, pk(0, 1, 2, 2, 0, 0, 0, 24'h0000F8)});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {out_valid, pk(o_need, o_det, o_kind, o_len, o_leg, o_ven, o_inv, o_pay)},
          {1'b1, pk(0, 0, 0, 0, 1, 0, 0, 24'h0)});
    @(negedge clk);
    check("R2", {EW'(0), out_valid}, {EW'(0), 1'b0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode32();
    t_mode64();
    t_wide();
    t_alt();
    t_short();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule